// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Logic

This block converts three digitized Hall-sensor levels from a brushless DC motor into enables for the six switches of a three-phase bridge. There is one high-side enable and one low-side enable per phase. It applies a direction level, an active-low brake, an active-high disable/standby level, a PWM-off request and a fault-off request. It also produces a tachometer level that inverts once per commutation step.

Every external level passes through a stability filter before it is used. The Hall bits need `HALL_STABLE` unchanged system clocks. The direction, brake and disable levels need `LOGIC_STABLE` clocks. The PWM-off and fault-off requests are unfiltered. The gate enables and the tachometer are registered. Dead time is inserted downstream.

Top module: `bldc_commutator`

## Requirements
- R1: With the direction level low, the filtered Hall code {U,V,W} drives one phase high and one phase low, and leaves the third phase with neither switch on. The codes map as follows: 101 → U high, V low; 100 → U high, W low; 110 → V high, W low; 010 → V high, U low; 011 → W high, U low; 001 → W high, V low. In the enable buses, bit 2 is U, bit 1 is V and bit 0 is W.
- R2: With the direction level high, every legal code drives the same two phases as in R1 with their polarity swapped.
- R3: Hall codes 000 and 111 turn all six switches off.
- R4: When the brake input is low and the disable input is low, all three low-side switches are on and all high-side switches are off, for any Hall code.
- R5: When the disable input is high, all six switches are off, whatever the brake level. This covers both the disable state and the standby state.
- R6: A high fault-off request overrides every other input. It turns all six switches off from the clock edge that samples it.
- R7: While the block is driving a legal code, a high PWM-off request clears the high-side enables and keeps the low-side enable. The request is ignored while braking.
- R8: No phase ever has its high-side and low-side enables asserted together.
- R9: The tachometer inverts once each time the filtered Hall code moves from one legal code to a different legal code. The move may pass through error codes. A return to the same legal code does not invert it, and neither does a change of direction, brake or disable.
- R10: A Hall code change is accepted only after it has been stable for `HALL_STABLE` clocks. A shorter pulse has no effect on the enables or the tachometer.
- R11: A change of direction, brake or disable is accepted only after it has been stable for `LOGIC_STABLE` clocks.
- R12: After reset, all enables are off and the tachometer is low. The filters start in the disabled state with Hall code 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Raw Hall levels, bit 2 = U, bit 1 = V, bit 0 = W |
| dir_in | input | 1 | Rotation direction, high reverses polarity |
| brake_n_in | input | 1 | Brake request, active low |
| disable_in | input | 1 | High disables the bridge (standby when brake is also low) |
| pwm_off | input | 1 | Chopping off-phase request, clears high sides |
| fault_off | input | 1 | Protection shutdown, forces all switches off |
| hi_en | output | 3 | High-side switch enables, bit 2 = U |
| lo_en | output | 3 | Low-side switch enables, bit 2 = U |
| tach_out | output | 1 | Tachometer level, toggles per commutation step |

## Verification
The six legal Hall codes are walked in rotation order under both direction levels. This distinguishes a wrong table row from a wrong polarity swap, and it shows a tachometer flip on every step. Error codes are inserted between legal codes, once returning to the same code and once moving to a new one, to separate a real step from an error round trip. Pulses one clock shorter than each filter window, followed by sustained changes, show whether the stability counters gate acceptance. Brake, disable and standby are applied with PWM-off and fault-off combinations to expose the override priority.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  typedef struct packed {
    logic [2:0] hi;
    logic [2:0] lo;
  } gate_t;

  function automatic logic hall_legal(input logic [2:0] code);
    return (code != 3'b000) && (code != 3'b111);
  endfunction

  // phase bits: [2]=U [1]=V [0]=W
  function automatic gate_t step_decode(input logic [2:0] code, input logic rev);
    gate_t g;
    case (code)
      3'b101:  g = '{hi: 3'b100, lo: 3'b010};
      3'b100:  g = '{hi: 3'b100, lo: 3'b001};
      3'b110:  g = '{hi: 3'b010, lo: 3'b001};
      3'b010:  g = '{hi: 3'b010, lo: 3'b100};
      3'b011:  g = '{hi: 3'b001, lo: 3'b100};
      3'b001:  g = '{hi: 3'b001, lo: 3'b010};
      default: g = '{hi: 3'b000, lo: 3'b000};
    endcase
    if (rev) g = '{hi: g.lo, lo: g.hi};
    return g;
  endfunction

endpackage

// File: rtl/bldc_glitch_filter.sv
module bldc_glitch_filter #(
  parameter int W         = 3,
  parameter int STABLE    = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [W-1:0]  cand_q;
  logic [W-1:0]  out_q;
  logic [CW-1:0] cnt_q;
  logic          accept_w;

  assign accept_w = (raw == cand_q) && (cand_q != out_q) && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= RESET_VAL;
      out_q  <= RESET_VAL;
      cnt_q  <= '0;
    end else if (raw != cand_q) begin
      cand_q <= raw;
      cnt_q  <= '0;
    end else if (cand_q != out_q) begin
      if (cnt_q == LAST) begin
        out_q <= cand_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign filt = out_q;

  AST_FILT_TAKES_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (out_q == $past(cand_q)));                        // R10
  AST_FILT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(out_q));                                 // R11
endmodule

// File: rtl/bldc_drive_logic.sv
module bldc_drive_logic
  import bldc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_f,
  input  logic       dir_f,
  input  logic       brake_n_f,
  input  logic       disable_f,
  input  logic       pwm_off,
  input  logic       fault_off,
  output logic [2:0] hi_en,
  output logic [2:0] lo_en
);
  gate_t step_w;
  gate_t next_w;
  gate_t gate_q;
  logic  braking_w;
  logic  idle_w;

  assign step_w    = step_decode(hall_f, dir_f);
  assign braking_w = !fault_off && !disable_f && !brake_n_f;
  assign idle_w    = fault_off || disable_f;

  always_comb begin
    next_w = '{hi: 3'b000, lo: 3'b000};
    if (idle_w) begin
      next_w = '{hi: 3'b000, lo: 3'b000};
    end else if (braking_w) begin
      next_w = '{hi: 3'b000, lo: 3'b111};
    end else begin
      next_w = step_w;
      if (pwm_off) next_w.hi = 3'b000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '{hi: 3'b000, lo: 3'b000};
    else        gate_q <= next_w;
  end

  assign hi_en = gate_q.hi;
  assign lo_en = gate_q.lo;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en & lo_en) == 3'b000);                                    // R8
  AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_off |=> (hi_en == 3'b000 && lo_en == 3'b000));           // R6
  AST_BRAKE_LOW_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
    braking_w |=> (lo_en == 3'b111 && hi_en == 3'b000));           // R4
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    disable_f |=> (hi_en == 3'b000 && lo_en == 3'b000));           // R5
  AST_ERROR_CODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!braking_w && !hall_legal(hall_f)) |=> (hi_en == 3'b000 && lo_en == 3'b000)); // R3
  AST_PWM_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_off && !braking_w) |=> (hi_en == 3'b000));                // R7
endmodule

// File: rtl/bldc_tach.sv
module bldc_tach
  import bldc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_f,
  output logic       tach
);
  logic [2:0] last_q;   // 000 = no legal code seen yet
  logic       tach_q;
  logic       step_evt;

  assign step_evt = hall_legal(hall_f) && (last_q != 3'b000) && (hall_f != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 3'b000;
      tach_q <= 1'b0;
    end else begin
      if (hall_legal(hall_f)) last_q <= hall_f;
      if (step_evt)           tach_q <= ~tach_q;
    end
  end

  assign tach = tach_q;

  AST_TACH_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (tach_q != $past(tach_q)));                       // R9
  AST_TACH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(tach_q));                                // R9
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator #(
  parameter int HALL_STABLE  = 400,
  parameter int LOGIC_STABLE = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_in,
  input  logic       brake_n_in,
  input  logic       disable_in,
  input  logic       pwm_off,
  input  logic       fault_off,
  output logic [2:0] hi_en,
  output logic [2:0] lo_en,
  output logic       tach_out
);
  logic [2:0] hall_f;
  logic [2:0] ctl_f;   // {dir, brake_n, disable}

  bldc_glitch_filter #(.W(3), .STABLE(HALL_STABLE), .RESET_VAL(3'b000)) u_hall_filt (
    .clk(clk), .rst_n(rst_n), .raw(hall_in), .filt(hall_f));

  bldc_glitch_filter #(.W(3), .STABLE(LOGIC_STABLE), .RESET_VAL(3'b011)) u_ctl_filt (
    .clk(clk), .rst_n(rst_n), .raw({dir_in, brake_n_in, disable_in}), .filt(ctl_f));

  bldc_drive_logic u_drive (
    .clk(clk), .rst_n(rst_n), .hall_f(hall_f),
    .dir_f(ctl_f[2]), .brake_n_f(ctl_f[1]), .disable_f(ctl_f[0]),
    .pwm_off(pwm_off), .fault_off(fault_off),
    .hi_en(hi_en), .lo_en(lo_en));

  bldc_tach u_tach (
    .clk(clk), .rst_n(rst_n), .hall_f(hall_f), .tach(tach_out));
endmodule

// File: tb/bldc_commutator_tb_top.sv
`timescale 1ns/1ps
module bldc_commutator_tb_top;
  localparam int HN = 16;
  localparam int LN = 4;
  // {hall, fwd_hi, fwd_lo} in rotation order
  localparam logic [8:0] VEC [6] = '{
    9'b101_100_010, 9'b100_100_001, 9'b110_010_001,
    9'b010_010_100, 9'b011_001_100, 9'b001_001_010 };

  logic clk = 0, rst_n = 0;
  logic [2:0] hall_in = 3'b000;
  logic dir_in = 0, brake_n_in = 1, disable_in = 1, pwm_off = 0, fault_off = 0;
  logic [2:0] hi_en, lo_en;
  logic tach_out;
  int total = 0, bad = 0;
  bit done = 0;
  logic t0;

  always #2.5 clk = ~clk;

  bldc_commutator #(.HALL_STABLE(HN), .LOGIC_STABLE(LN)) dut_i (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_in(dir_in),
    .brake_n_in(brake_n_in), .disable_in(disable_in), .pwm_off(pwm_off),
    .fault_off(fault_off), .hi_en(hi_en), .lo_en(lo_en), .tach_out(tach_out));

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle(); wait_n(HN + 4); endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R12 reset", {hi_en, lo_en, tach_out}, 7'b0);
    rst_n = 1;
    wait_n(2);
    chk("R12 after reset", {hi_en, lo_en, tach_out}, 7'b0);
    disable_in = 0;
    hall_in = VEC[5][8:6];
    settle();
    // forward walk
    for (int i = 0; i < 6; i++) begin
      t0 = tach_out;
      hall_in = VEC[i][8:6];
      settle();
      chk("R1 forward", {hi_en, lo_en, 1'b0}, {VEC[i][5:3], VEC[i][2:0], 1'b0});
      chk("R9 step toggle", {6'b0, tach_out}, {6'b0, ~t0});
      chk("R8 no overlap", {4'b0, hi_en & lo_en}, 7'b0);
    end
    // reverse
    t0 = tach_out;
    dir_in = 1;
    wait_n(LN + 4);
    chk("R9 dir no toggle", {6'b0, tach_out}, {6'b0, t0});
    for (int i = 0; i < 6; i++) begin
      hall_in = VEC[i][8:6];
      settle();
      chk("R2 reverse", {hi_en, lo_en, 1'b0}, {VEC[i][2:0], VEC[i][5:3], 1'b0});
      chk("R8 no overlap", {4'b0, hi_en & lo_en}, 7'b0);
    end
    dir_in = 0;
    wait_n(LN + 4);
    // error codes
    t0 = tach_out;
    hall_in = 3'b000; settle();
    chk("R3 code 000", {hi_en, lo_en, tach_out}, {6'b0, t0});
    hall_in = 3'b001; settle();
    chk("R9 same code after error", {6'b0, tach_out}, {6'b0, t0});
    hall_in = 3'b111; settle();
    chk("R3 code 111", {hi_en, lo_en, 1'b0}, 7'b0);
    hall_in = 3'b101; settle();
    chk("R9 new code after error", {6'b0, tach_out}, {6'b0, ~t0});
    chk("R1 after error", {hi_en, lo_en, 1'b0}, 7'b100_010_0);
    // R10 glitch shorter than window
    t0 = tach_out;
    hall_in = 3'b100; wait_n(HN - 1);
    hall_in = 3'b101; settle();
    chk("R10 glitch ignored", {hi_en, lo_en, tach_out}, {6'b100_010, t0});
    // R11 short dir pulse ignored, long one accepted
    dir_in = 1; wait_n(LN - 1);
    dir_in = 0; wait_n(LN + 4);
    chk("R11 short pulse", {hi_en, lo_en, 1'b0}, 7'b100_010_0);
    dir_in = 1; wait_n(LN + 3);
    chk("R11 accepted", {hi_en, lo_en, 1'b0}, 7'b010_100_0);
    dir_in = 0; wait_n(LN + 4);
    // R7 pwm off
    pwm_off = 1; wait_n(1);
    chk("R7 pwm off", {hi_en, lo_en, 1'b0}, 7'b000_010_0);
    // R4 brake, pwm ignored
    t0 = tach_out;
    brake_n_in = 0; wait_n(LN + 4);
    chk("R4 brake with pwm off R7", {hi_en, lo_en, tach_out}, {6'b000_111, t0});
    pwm_off = 0;
    hall_in = 3'b111; settle();
    chk("R4 brake on error code", {hi_en, lo_en, 1'b0}, 7'b000_111_0);
    hall_in = 3'b101; settle();
    // R6 fault overrides brake
    fault_off = 1; wait_n(1);
    chk("R6 fault over brake", {hi_en, lo_en, 1'b0}, 7'b0);
    fault_off = 0; wait_n(1);
    chk("R4 brake resumes", {hi_en, lo_en, 1'b0}, 7'b000_111_0);
    // R5 standby and disable
    disable_in = 1; wait_n(LN + 4);
    chk("R5 standby", {hi_en, lo_en, 1'b0}, 7'b0);
    brake_n_in = 1; wait_n(LN + 4);
    chk("R5 disable", {hi_en, lo_en, 1'b0}, 7'b0);
    disable_in = 0; wait_n(LN + 4);
    chk("R1 resume", {hi_en, lo_en, 1'b0}, 7'b100_010_0);
    fault_off = 1; wait_n(1);
    chk("R6 fault over drive", {hi_en, lo_en, 1'b0}, 7'b0);
    fault_off = 0;
    wait_n(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule